// File: doc/BRIEF.md
# Double-Buffered 10-Bit PWM Generator

This block drives one pulse-width-modulated output. An 8-bit timer counts up to a programmable period value and then wraps. Below the timer, a sub-count provides two extra fine bits, so the duty comparison runs at 10-bit resolution. A selectable prescaler stretches each timer step to 4, 16 or 64 input clocks.

The duty value is written as an 8-bit upper part and a 2-bit lower part. Each part has its own write strobe, and either can be written at any time. The written value waits in a pending register. It is copied into an active register only at a period boundary, so a duty change never cuts a pulse short or stretches it. The active value can be read back on a port.

An enable input holds the time base at zero and the output low while it is low. When enable goes high, a fresh period starts with the pending duty value already in force.

Top module: `pwm_dbuf_gen`

## Requirements
- R1: The output period is (period + 1) × 4 × P input clocks. P is set by `presc_sel`: 0 gives 1, 1 gives 4, and 2 or 3 give 16.
- R2: One step after the timer equals the period value, the timer and sub-count clear to zero and a new period begins. The output is high from the first clock of that period, unless the duty value is zero.
- R3: For an active duty value D with 0 < D < 4 × (period + 1), the output is high for exactly D × P input clocks at the start of each period and low for the rest.
- R4: A written duty value reaches `duty_active_o`, and takes control of the output, only at the next period boundary or while the block is disabled. Until then, the active value and the current pulse are unchanged.
- R5: An active duty value of zero keeps the output low for the whole period.
- R6: An active duty value of 4 × (period + 1) or more keeps the output high for the whole period.
- R7: While `en` is low, the output is low and the time base is held at zero. The pending duty value is loaded into the active register. The first period starts on the first clock edge at which `en` is sampled high, and the output is high from that edge.
- R8: A write to the low part changes only duty bits [1:0]. A write to the high part changes only duty bits [9:2].
- R9: After reset, `pwm_o` is low and `duty_active_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the time base at zero |
| presc_sel | input | 2 | Prescale select: 0 = 1, 1 = 4, 2 or 3 = 16 |
| per_we | input | 1 | Period register write strobe |
| per_wdata | input | 8 | Period value |
| duty_hi_we | input | 1 | Duty upper-part write strobe |
| duty_hi_wdata | input | 8 | Duty bits [9:2] |
| duty_lo_we | input | 1 | Duty lower-part write strobe |
| duty_lo_wdata | input | 2 | Duty bits [1:0] |
| pwm_o | output | 1 | PWM output |
| duty_active_o | output | 10 | Latched active duty value |

## Verification
The hardest case to reach is a duty write that lands in the middle of a running period. To prove double buffering, the current pulse must keep its old width, and the new width must appear exactly at the next boundary. The stimulus starts a 40-clock period with duty 8. Ten clocks in, after the pulse has ended, it writes duty 20 and checks that the read-back still shows 8. It then measures the high time of two back-to-back period windows.

The edge cases are duty zero and duty at or above the period length. Neither produces an output edge, so every window is measured by counting high clocks over a fixed number of cycles, starting from the enable edge.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'd0,
    PS_DIV4   = 2'd1,
    PS_DIV16  = 2'd2,
    PS_DIV16X = 2'd3
  } presc_e;

  // log2 of the prescale ratio for each select code
  function automatic int unsigned presc_shift(presc_e sel);
    case (sel)
      PS_DIV1: presc_shift = 0;
      PS_DIV4: presc_shift = 2;
      default: presc_shift = 4;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_dbuf_pkg::*;
#(
  parameter int FINE_W    = 2,
  parameter int SHIFT_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  presc_e            sel,
  output logic              step,
  output logic [FINE_W-1:0] fine_nxt
);
  localparam int SUB_W = FINE_W + SHIFT_MAX;

  logic [SUB_W-1:0] sub_q, sub_n, sub_last;
  int unsigned      shift;

  always_comb begin
    shift    = presc_shift(sel);
    sub_last = SUB_W'((64'd1 << (FINE_W + shift)) - 64'd1);
    step     = (sub_q == sub_last);
    if (clr || step) sub_n = '0;
    else             sub_n = sub_q + 1'b1;
    fine_nxt = FINE_W'(sub_n >> shift);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_q <= '0;
    else        sub_q <= sub_n;
  end

  // R1: a completed step always restarts the sub-count
  p_step_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (sub_q == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [TMR_W-1:0] period,
  output logic             roll,
  output logic [TMR_W-1:0] tmr_nxt
);
  logic [TMR_W-1:0] tmr_q;

  always_comb begin
    roll = step && (tmr_q == period);
    if (clr || roll) tmr_nxt = '0;
    else if (step)   tmr_nxt = tmr_q + 1'b1;
    else             tmr_nxt = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_nxt;
  end

  // R2: timer is zero right after a period match
  p_timer_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (tmr_q == '0));

endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int HI_W = 8,
  parameter int LO_W = 2,
  localparam int DUTY_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_we,
  input  logic [HI_W-1:0]   hi_d,
  input  logic              lo_we,
  input  logic [LO_W-1:0]   lo_d,
  input  logic              load,
  output logic [DUTY_W-1:0] act_q,
  output logic [DUTY_W-1:0] act_nxt
);
  logic [HI_W-1:0] pend_hi_q, pend_hi_n;
  logic [LO_W-1:0] pend_lo_q, pend_lo_n;

  always_comb begin
    pend_hi_n = hi_we ? hi_d : pend_hi_q;
    pend_lo_n = lo_we ? lo_d : pend_lo_q;
    act_nxt   = load ? {pend_hi_q, pend_lo_q} : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi_q <= '0;
      pend_lo_q <= '0;
      act_q     <= '0;
    end else begin
      pend_hi_q <= pend_hi_n;
      pend_lo_q <= pend_lo_n;
      act_q     <= act_nxt;
    end
  end

  // R4: the active value never moves between boundaries
  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act_q));

  // R8: writing one part leaves the other pending part alone
  p_lo_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !hi_we) |=> $stable(pend_hi_q));

endmodule

// File: rtl/pwm_dbuf_gen.sv
module pwm_dbuf_gen
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W     = 8,
  parameter int FINE_W    = 2,
  parameter int SHIFT_MAX = 4,
  localparam int DUTY_W   = TMR_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        presc_sel,
  input  logic              per_we,
  input  logic [TMR_W-1:0]  per_wdata,
  input  logic              duty_hi_we,
  input  logic [TMR_W-1:0]  duty_hi_wdata,
  input  logic              duty_lo_we,
  input  logic [FINE_W-1:0] duty_lo_wdata,
  output logic              pwm_o,
  output logic [DUTY_W-1:0] duty_active_o
);
  logic [TMR_W-1:0]  period_q, period_n;
  logic              run_q, pwm_q, pwm_n;
  logic              restart, roll, step, load, match_nxt;
  logic [TMR_W-1:0]  tmr_nxt;
  logic [FINE_W-1:0] fine_nxt;
  logic [DUTY_W-1:0] act_q, act_nxt;
  presc_e            sel;

  assign sel     = presc_e'(presc_sel);
  assign restart = en && !run_q;
  assign load    = !en || restart || roll;

  pwm_prescaler #(.FINE_W(FINE_W), .SHIFT_MAX(SHIFT_MAX)) i_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (load),
    .sel      (sel),
    .step     (step),
    .fine_nxt (fine_nxt)
  );

  pwm_timebase #(.TMR_W(TMR_W)) i_tbase (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .step    (step),
    .period  (period_q),
    .roll    (roll),
    .tmr_nxt (tmr_nxt)
  );

  pwm_duty_buf #(.HI_W(TMR_W), .LO_W(FINE_W)) i_dbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_we   (duty_hi_we),
    .hi_d    (duty_hi_wdata),
    .lo_we   (duty_lo_we),
    .lo_d    (duty_lo_wdata),
    .load    (load),
    .act_q   (act_q),
    .act_nxt (act_nxt)
  );

  // compare against the state the counters move to, so the output register
  // changes on the same edge as the counters
  always_comb begin
    period_n  = per_we ? per_wdata : period_q;
    match_nxt = ({tmr_nxt, fine_nxt} == act_nxt);
    if (!en)                  pwm_n = 1'b0;
    else if (match_nxt)       pwm_n = 1'b0;
    else if (restart || roll) pwm_n = 1'b1;
    else                      pwm_n = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      run_q    <= 1'b0;
      pwm_q    <= 1'b0;
    end else begin
      period_q <= period_n;
      run_q    <= en;
      pwm_q    <= pwm_n;
    end
  end

  assign pwm_o         = pwm_q;
  assign duty_active_o = act_q;

  // R7: disabled means low output on the following cycle
  p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_o);

  // R2: the output only rises when a period begins
  p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_q) |-> $past(restart || roll));

  // R5: zero duty taken at a boundary gives no high level
  p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && act_nxt == '0) |=> !pwm_o);

endmodule

// File: tb/test_pwm_dbuf_gen.sv
module test_pwm_dbuf_gen;
  localparam int CLK_NS = 10;

  logic       clk, rst_n, en;
  logic [1:0] presc_sel;
  logic       per_we, duty_hi_we, duty_lo_we;
  logic [7:0] per_wdata, duty_hi_wdata;
  logic [1:0] duty_lo_wdata;
  logic       pwm_o;
  logic [9:0] duty_active_o;

  pwm_dbuf_gen i_pwm_dbuf_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .presc_sel(presc_sel),
    .per_we(per_we), .per_wdata(per_wdata),
    .duty_hi_we(duty_hi_we), .duty_hi_wdata(duty_hi_wdata),
    .duty_lo_we(duty_lo_we), .duty_lo_wdata(duty_lo_wdata),
    .pwm_o(pwm_o), .duty_active_o(duty_active_o)
  );

  typedef struct {
    int    high_a;
    int    high_b;
    int    per;
    int    duty_end;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  bit   mon_done;
  event start_ev;

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pre_of(int ps);
    return (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
  endfunction

  function automatic int high_of(int pr, int ps, int d);
    int p = pre_of(ps);
    if (d == 0) return 0;
    if (d >= 4 * (pr + 1)) return (pr + 1) * 4 * p;
    return d * p;
  endfunction

  task automatic write_duty(int d);
    @(negedge clk);
    duty_hi_we = 1'b1; duty_hi_wdata = 8'(d >> 2);
    duty_lo_we = 1'b1; duty_lo_wdata = 2'(d);
    @(negedge clk);
    duty_hi_we = 1'b0; duty_lo_we = 1'b0;
  endtask

  // driver: program, push expectation, start, optionally rewrite duty mid-period
  task automatic run_case(string tag, int pr, int ps, int d1, int d2, bit mid);
    exp_t e;
    @(negedge clk);
    en = 1'b0;
    per_we = 1'b1; per_wdata = 8'(pr); presc_sel = 2'(ps);
    @(negedge clk);
    per_we = 1'b0;
    write_duty(d1);
    e.per      = (pr + 1) * 4 * pre_of(ps);
    e.high_a   = high_of(pr, ps, d1);
    e.high_b   = high_of(pr, ps, mid ? d2 : d1);
    e.duty_end = mid ? d2 : d1;
    e.tag      = tag;
    q.push_back(e);
    mon_done = 1'b0;
    @(negedge clk);
    en = 1'b1;
    -> start_ev;
    if (mid) begin
      repeat (10) @(negedge clk);
      duty_hi_we = 1'b1; duty_hi_wdata = 8'(d2 >> 2);
      duty_lo_we = 1'b1; duty_lo_wdata = 2'(d2);
      @(negedge clk);
      duty_hi_we = 1'b0; duty_lo_we = 1'b0;
      check({tag, " R4 active held after mid write"}, int'(duty_active_o), d1);
    end
    wait (mon_done);
  endtask

  // monitor: counts high clocks over two period windows from the enable edge
  initial begin
    forever begin
      exp_t e;
      int ha, hb;
      @(start_ev);
      e = q.pop_front();
      ha = 0; hb = 0;
      @(posedge clk);
      for (int i = 0; i < 2 * e.per; i++) begin
        @(negedge clk);
        if (pwm_o) begin
          if (i < e.per) ha++;
          else hb++;
        end
      end
      check({e.tag, " first window high"}, ha, e.high_a);
      check({e.tag, " second window high"}, hb, e.high_b);
      check({e.tag, " R4 active duty at end"}, int'(duty_active_o), e.duty_end);
      mon_done = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; presc_sel = 2'd0;
    per_we = 1'b0; per_wdata = '0;
    duty_hi_we = 1'b0; duty_hi_wdata = '0;
    duty_lo_we = 1'b0; duty_lo_wdata = '0;
    repeat (3) @(negedge clk);
    check("R9 pwm after reset", int'(pwm_o), 0);
    check("R9 active duty after reset", int'(duty_active_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_case("R1 R3 pr3 div1 d5",    3,   0, 5,    0, 1'b0);
    run_case("R1 R3 pr7 div4 d10",   7,   1, 10,   0, 1'b0);
    run_case("R1 R3 pr2 div16 d7",   2,   2, 7,    0, 1'b0);
    run_case("R1 R3 pr1 sel3 d3",    1,   3, 3,    0, 1'b0);
    run_case("R5 zero duty",         4,   0, 0,    0, 1'b0);
    run_case("R6 duty over period",  4,   0, 25,   0, 1'b0);
    run_case("R6 duty equals period",4,   0, 20,   0, 1'b0);
    run_case("R3 duty one short",    4,   0, 19,   0, 1'b0);
    run_case("R2 pr0 div1 d2",       0,   0, 2,    0, 1'b0);
    run_case("R3 full res d1023",    255, 0, 1023, 0, 1'b0);
    run_case("R4 mid-period write",  9,   0, 8,    20, 1'b1);

    // R7: dropping enable while high forces the output low
    run_case("R7 restart d25", 4, 0, 25, 0, 1'b0);
    @(negedge clk);
    check("R7 still high before disable", int'(pwm_o), 1);
    en = 1'b0;
    @(negedge clk);
    check("R7 low after disable", int'(pwm_o), 0);

    // R8: low-part write alone; disabled block loads pending into active
    @(negedge clk);
    duty_lo_we = 1'b1; duty_lo_wdata = 2'd2;
    @(negedge clk);
    duty_lo_we = 1'b0;
    @(negedge clk);
    check("R8 low part only", int'(duty_active_o), 26);
    duty_hi_we = 1'b1; duty_hi_wdata = 8'd3;
    @(negedge clk);
    duty_hi_we = 1'b0;
    @(negedge clk);
    check("R8 high part only", int'(duty_active_o), 14);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule